// File: doc/BRIEF.md
# Instruction Cycle Phase Sequencer

This block is the control sequencer of a simple accumulator-style processor. It moves the machine through four phases. Fetch brings an instruction word into the instruction register. Indirect resolves an operand address through memory. Execute hands control to the datapath. Interrupt saves the program counter to memory and jumps to a service routine.

The block owns the four registers that these phases move data between: the program counter (PC), the memory address register (MAR), the memory buffer register (MBR) and the instruction register (IR). It drives a single-port memory with a read strobe, a write strobe, an address and write data. It expects read data to be returned combinationally in the same cycle as the read strobe.

The instruction-specific work of the execute phase is outside the block. The sequencer raises `exec_go` and waits for `exec_done`. On the cycle that `exec_done` is seen, it picks the next phase. It enters interrupt when an interrupt is pending and the interrupt enable flag is set, and otherwise returns to fetch.

The state machine has ten states:

| Group | States | Meaning |
|---|---|---|
| Fetch | ST_F1, ST_F2, ST_F3 | The three fetch time units |
| Indirect | ST_D1, ST_D2, ST_D3 | The three indirect time units |
| Execute | ST_EX | Wait for the datapath |
| Interrupt | ST_V1, ST_V2, ST_V3 | The three interrupt time units |

Its transitions are:

| From | To | Condition |
|---|---|---|
| ST_F1 | ST_F2 | Always |
| ST_F2 | ST_F3 | Always |
| ST_F3 | ST_D1 | Indirect bit of the fetched word is set |
| ST_F3 | ST_EX | Indirect bit of the fetched word is clear |
| ST_D1 | ST_D2 | Always |
| ST_D2 | ST_D3 | Always |
| ST_D3 | ST_EX | Always |
| ST_EX | ST_EX | `exec_done` low |
| ST_EX | ST_V1 | `exec_done` high, interrupt pending, enable flag set |
| ST_EX | ST_F1 | `exec_done` high, no interrupt is taken |
| ST_V1 | ST_V2 | Always |
| ST_V2 | ST_V3 | Always |
| ST_V3 | ST_F1 | Always |

Top module: `phase_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the outputs show phase 00 and time unit 0. PC equals BOOT_PC, the enable flag is 0, IR is 0, and both memory strobes are low.
- R2: The `phase` output encodes 00 for fetch, 01 for indirect, 10 for execute and 11 for interrupt. `tunit` counts 0, 1, 2 through the time units of fetch, indirect and interrupt, and each time unit lasts one clock. `tunit` is 0 throughout execute.
- R3: Fetch runs in three time units:
    - Unit 0 copies PC to MAR. `mem_addr` always shows MAR.
    - Unit 1 raises `mem_rd` with `mem_addr` equal to PC, captures `mem_rdata` into MBR and advances PC by ILEN.
    - Unit 2 copies MBR into IR.
- R4: After fetch unit 2, the next phase is indirect (01) if bit DW-1 of the fetched word is 1, and execute (10) otherwise.
- R5: Indirect runs in three time units:
    - Unit 0 copies IR bits AW-1:0 to MAR.
    - Unit 1 reads memory into MBR.
    - Unit 2 replaces IR bits AW-1:0 with MBR bits AW-1:0 and keeps the upper IR bits.
    - Indirect is always followed by execute.
- R6: In execute, `exec_go` is 1, and the phase stays 10 for every cycle that `exec_done` is low. `exec_go` is 0 in every other phase.
- R7: When `exec_done` is high in execute, the next phase is interrupt (11) only if `irq_pend` and the enable flag are both 1. Otherwise it is fetch (00). A pending interrupt with the flag at 0 is ignored.
- R8: Interrupt runs in three time units:
    - Unit 0 copies PC (already advanced past the last instruction) into MBR.
    - Unit 1 loads MAR with SAVE_ADDR and PC with VEC_ADDR.
    - Unit 2 raises `mem_wr` with `mem_addr` equal to SAVE_ADDR and `mem_wdata` equal to the saved PC, zero-extended.
    - Interrupt is always followed by fetch from VEC_ADDR.
- R9: `ie_set` sets the enable flag, and entering interrupt clears it. If both occur on the same edge, the clear wins. The flag reads 0 in every interrupt time unit 0.
- R10: `mem_rd` is high only in unit 1 of fetch or indirect. `mem_wr` is high only in unit 2 of interrupt. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | DW | Memory read data, valid in the cycle `mem_rd` is high |
| exec_done | input | 1 | Datapath has finished the execute phase |
| irq_pend | input | 1 | An interrupt request is pending |
| ie_set | input | 1 | Sets the interrupt enable flag |
| phase | output | 2 | Current phase code |
| tunit | output | 2 | Time unit within the phase |
| mem_addr | output | AW | Memory address (MAR) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data (MBR) |
| ir | output | DW | Instruction register |
| pc | output | AW | Program counter |
| exec_go | output | 1 | Execute phase active |
| ie | output | 1 | Interrupt enable flag |

## Verification
Most wrong internal states appear at the `phase` or `tunit` ports within one clock, so a per-cycle comparison against a behavioural model catches them on the next falling edge.

Some mistakes change only where the memory is addressed:

- A wrong MAR source shows on `mem_addr` within one time unit.
- A wrong PC advance shows on `pc` in the cycle after fetch unit 1.

Other mistakes stay hidden for longer:

- A lost enable clear or a wrong save value surfaces only at the next execute exit, or at the write in interrupt unit 2.
- These are covered by checking the saved memory word and by counting both taken and ignored interrupts.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

    typedef enum logic [1:0] {
        PH_FETCH = 2'b00,
        PH_INDIR = 2'b01,
        PH_EXEC  = 2'b10,
        PH_INTR  = 2'b11
    } phase_e;

    typedef enum logic [3:0] {
        ST_F1, ST_F2, ST_F3,
        ST_D1, ST_D2, ST_D3,
        ST_EX,
        ST_V1, ST_V2, ST_V3
    } state_e;

    typedef struct packed {
        logic pc_to_mar;
        logic mem_to_mbr;
        logic pc_adv;
        logic mbr_to_ir;
        logic ira_to_mar;
        logic mbr_to_ira;
        logic pc_to_mbr;
        logic vec_load;
        logic mem_wr;
        logic ie_clr;
    } xfer_t;

endpackage

// File: rtl/phase_fsm.sv
module phase_fsm
    import phase_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ind_bit,
    input  logic   exec_done,
    input  logic   irq_take,
    output phase_e phase,
    output logic [1:0] tunit,
    output xfer_t  ctl,
    output logic   exec_go
);

    state_e st_q, st_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_F1;
        else        st_q <= st_nx;
    end

    // next-state selection
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_F1:   st_nx = ST_F2;
            ST_F2:   st_nx = ST_F3;
            ST_F3:   st_nx = ind_bit ? ST_D1 : ST_EX;
            ST_D1:   st_nx = ST_D2;
            ST_D2:   st_nx = ST_D3;
            ST_D3:   st_nx = ST_EX;
            ST_EX:   if (exec_done) st_nx = irq_take ? ST_V1 : ST_F1;
            ST_V1:   st_nx = ST_V2;
            ST_V2:   st_nx = ST_V3;
            ST_V3:   st_nx = ST_F1;
            default: st_nx = ST_F1;
        endcase
    end

    // outputs and transfer strobes
    always_comb begin
        ctl     = '0;
        phase   = PH_FETCH;
        tunit   = 2'd0;
        exec_go = 1'b0;
        unique case (st_q)
            ST_F1: begin
                ctl.pc_to_mar = 1'b1;
            end
            ST_F2: begin
                tunit          = 2'd1;
                ctl.mem_to_mbr = 1'b1;
                ctl.pc_adv     = 1'b1;
            end
            ST_F3: begin
                tunit         = 2'd2;
                ctl.mbr_to_ir = 1'b1;
            end
            ST_D1: begin
                phase          = PH_INDIR;
                ctl.ira_to_mar = 1'b1;
            end
            ST_D2: begin
                phase          = PH_INDIR;
                tunit          = 2'd1;
                ctl.mem_to_mbr = 1'b1;
            end
            ST_D3: begin
                phase          = PH_INDIR;
                tunit          = 2'd2;
                ctl.mbr_to_ira = 1'b1;
            end
            ST_EX: begin
                phase      = PH_EXEC;
                exec_go    = 1'b1;
                ctl.ie_clr = exec_done & irq_take;
            end
            ST_V1: begin
                phase         = PH_INTR;
                ctl.pc_to_mbr = 1'b1;
            end
            ST_V2: begin
                phase        = PH_INTR;
                tunit        = 2'd1;
                ctl.vec_load = 1'b1;
            end
            ST_V3: begin
                phase      = PH_INTR;
                tunit      = 2'd2;
                ctl.mem_wr = 1'b1;
            end
            default: begin
                phase = PH_FETCH;
            end
        endcase
    end

endmodule

// File: rtl/xfer_regs.sv
module xfer_regs
    import phase_seq_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 16,
    parameter int ILEN      = 1,
    parameter int SAVE_ADDR = 0,
    parameter int VEC_ADDR  = 1,
    parameter int BOOT_PC   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_t         ctl,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mbr,
    output logic [DW-1:0] ir,
    output logic          ind_bit
);

    localparam logic [AW-1:0] STEP  = AW'(ILEN);
    localparam logic [AW-1:0] SAVEA = AW'(SAVE_ADDR);
    localparam logic [AW-1:0] VECA  = AW'(VEC_ADDR);
    localparam logic [AW-1:0] BOOTA = AW'(BOOT_PC);

    logic [DW-1:0] pc_wide;

    generate
        if (DW > AW) begin : g_pad
            assign pc_wide = {{(DW-AW){1'b0}}, pc};
        end else begin : g_trunc
            assign pc_wide = pc[DW-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= BOOTA;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
        end else begin
            if (ctl.pc_to_mar)  mar <= pc;
            if (ctl.ira_to_mar) mar <= ir[AW-1:0];
            if (ctl.vec_load) begin
                mar <= SAVEA;
                pc  <= VECA;
            end
            if (ctl.pc_adv)     pc  <= pc + STEP;
            if (ctl.mem_to_mbr) mbr <= mem_rdata;
            if (ctl.pc_to_mbr)  mbr <= pc_wide;
            if (ctl.mbr_to_ir)  ir  <= mbr;
            if (ctl.mbr_to_ira) ir[AW-1:0] <= mbr[AW-1:0];
        end
    end

    assign ind_bit = mbr[DW-1];

endmodule

// File: rtl/irq_gate.sv
module irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_pend,
    input  logic ie_set,
    input  logic ie_clr,
    output logic ie,
    output logic irq_take
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ie <= 1'b0;
        else if (ie_clr) ie <= 1'b0;
        else if (ie_set) ie <= 1'b1;
    end

    assign irq_take = irq_pend & ie;

endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer
    import phase_seq_pkg::*;
#(
    parameter int AW        = 12,
    parameter int DW        = 16,
    parameter int ILEN      = 1,
    parameter int SAVE_ADDR = 0,
    parameter int VEC_ADDR  = 1,
    parameter int BOOT_PC   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_rdata,
    input  logic          exec_done,
    input  logic          irq_pend,
    input  logic          ie_set,
    output logic [1:0]    phase,
    output logic [1:0]    tunit,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] ir,
    output logic [AW-1:0] pc,
    output logic          exec_go,
    output logic          ie
);

    xfer_t   ctl;
    phase_e  ph;
    logic    ind_bit;
    logic    irq_take;
    logic [AW-1:0] mar;
    logic [DW-1:0] mbr;

    phase_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ind_bit   (ind_bit),
        .exec_done (exec_done),
        .irq_take  (irq_take),
        .phase     (ph),
        .tunit     (tunit),
        .ctl       (ctl),
        .exec_go   (exec_go)
    );

    xfer_regs #(
        .AW(AW), .DW(DW), .ILEN(ILEN),
        .SAVE_ADDR(SAVE_ADDR), .VEC_ADDR(VEC_ADDR), .BOOT_PC(BOOT_PC)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir),
        .ind_bit   (ind_bit)
    );

    irq_gate i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_pend (irq_pend),
        .ie_set   (ie_set),
        .ie_clr   (ctl.ie_clr),
        .ie       (ie),
        .irq_take (irq_take)
    );

    assign phase     = ph;
    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign mem_rd    = ctl.mem_to_mbr;
    assign mem_wr    = ctl.mem_wr;

endmodule

// File: rtl/phase_sequencer_chk.sv
module phase_sequencer_chk #(
    parameter int AW        = 12,
    parameter int ILEN      = 1,
    parameter int SAVE_ADDR = 0,
    parameter int VEC_ADDR  = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    phase,
    input logic [1:0]    tunit,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          ie,
    input logic          exec_done
);

    AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R10

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 && tunit == 2'd1) |=> (pc == $past(pc) + AW'(ILEN))); // R3

    AST_IND_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b01 && tunit == 2'd2) |=> (phase == 2'b10)); // R5

    AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10 && !exec_done) |=> (phase == 2'b10)); // R6

    AST_EXEC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10 && exec_done) |=> (phase == 2'b00 || phase == 2'b11)); // R7

    AST_INTR_IE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b11 && tunit == 2'd0) |-> !ie); // R9

    AST_SAVE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == AW'(SAVE_ADDR) && pc == AW'(VEC_ADDR))); // R8

    AST_INTR_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b11 && tunit == 2'd2) |=> (phase == 2'b00 && tunit == 2'd0)); // R8

endmodule

bind phase_sequencer phase_sequencer_chk #(
    .AW(AW), .ILEN(ILEN), .SAVE_ADDR(SAVE_ADDR), .VEC_ADDR(VEC_ADDR)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .tunit     (tunit),
    .pc        (pc),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .ie        (ie),
    .exec_done (exec_done)
);

// File: tb/test_phase_sequencer.sv
module test_phase_sequencer;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int BOOT = 16;
    localparam int SAVEA = 0;
    localparam int VECA = 1;
    localparam int RUN_CYC = 800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exec_done = 1'b0;
    logic irq_pend = 1'b0;
    logic ie_set = 1'b0;
    logic [DW-1:0] mem_rdata;
    logic [1:0] phase, tunit;
    logic [AW-1:0] mem_addr, pc;
    logic mem_rd, mem_wr, exec_go, ie;
    logic [DW-1:0] mem_wdata, ir;

    logic [DW-1:0] mem [0:255];

    always #10 clk = ~clk;

    phase_sequencer #(
        .AW(AW), .DW(DW), .ILEN(1),
        .SAVE_ADDR(SAVEA), .VEC_ADDR(VECA), .BOOT_PC(BOOT)
    ) i_phase_sequencer (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata),
        .exec_done(exec_done), .irq_pend(irq_pend), .ie_set(ie_set),
        .phase(phase), .tunit(tunit), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .ir(ir), .pc(pc), .exec_go(exec_go), .ie(ie)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference model state
    int m_ph, m_t, m_pph, m_pt;
    logic [AW-1:0] m_pc, m_mar;
    logic [DW-1:0] m_mbr, m_ir;
    logic m_ie, take, nie;
    int n_intr = 0;
    int n_ign = 0;
    bit saved_chk = 0;
    logic [DW-1:0] exp_saved;

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++)
                mem[i] <= (i % 3 == 0) ? (16'h8000 | 16'(12'h0C0 + (i % 32)))
                                       : (16'h1000 | 16'(i));
            m_ph = 0; m_t = 0; m_pph = 0; m_pt = 0;
            m_pc = AW'(BOOT); m_mar = '0; m_mbr = '0; m_ir = '0; m_ie = 1'b0;
        end else begin
            m_pph = m_ph; m_pt = m_t;
            take = exec_done && irq_pend && m_ie;
            nie = ie_set ? 1'b1 : m_ie;
            case (m_ph)
                0: begin
                    if (m_t == 0) begin m_mar = m_pc; m_t = 1; end
                    else if (m_t == 1) begin
                        m_mbr = mem[m_mar[7:0]]; m_pc = m_pc + 1'b1; m_t = 2;
                    end else begin
                        m_ir = m_mbr; m_ph = m_mbr[15] ? 1 : 2; m_t = 0;
                    end
                end
                1: begin
                    if (m_t == 0) begin m_mar = m_ir[11:0]; m_t = 1; end
                    else if (m_t == 1) begin m_mbr = mem[m_mar[7:0]]; m_t = 2; end
                    else begin
                        m_ir = {m_ir[15:12], m_mbr[11:0]}; m_ph = 2; m_t = 0;
                    end
                end
                2: begin
                    if (exec_done) begin
                        if (take) begin m_ph = 3; nie = 1'b0; n_intr++; end
                        else begin m_ph = 0; if (irq_pend) n_ign++; end
                    end
                end
                default: begin
                    if (m_t == 0) begin m_mbr = {4'b0, m_pc}; m_t = 1; end
                    else if (m_t == 1) begin
                        m_mar = AW'(SAVEA); m_pc = AW'(VECA); m_t = 2;
                    end else begin
                        exp_saved = m_mbr; saved_chk = 1; m_ph = 0; m_t = 0;
                    end
                end
            endcase
            m_ie = nie;
            if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic compare_all();
        string ptag;
        if (m_pph == 0 && m_pt == 2) ptag = "R4";
        else if (m_pph == 2) ptag = "R7";
        else ptag = "R2";
        chk(ptag, 32'(phase), 32'(m_ph), "phase");
        chk("R2", 32'(tunit), 32'(m_t), "tunit");
        chk("R3", 32'(pc), 32'(m_pc), "pc");
        chk("R3", 32'(mem_addr), 32'(m_mar), "mem_addr");
        chk("R5", 32'(ir), 32'(m_ir), "ir");
        chk("R10", 32'(mem_rd), 32'((m_ph == 0 || m_ph == 1) && m_t == 1), "mem_rd");
        chk("R10", 32'(mem_wr), 32'(m_ph == 3 && m_t == 2), "mem_wr");
        chk("R9", 32'(ie), 32'(m_ie), "ie");
        chk("R6", 32'(exec_go), 32'(m_ph == 2), "exec_go");
        if (mem_wr) chk("R8", 32'(mem_wdata), 32'(m_mbr), "mem_wdata");
        if (saved_chk && !mem_wr) begin
            chk("R8", 32'(mem[SAVEA]), 32'(exp_saved), "saved pc word");
            saved_chk = 0;
        end
    endtask

    initial begin
        int ex_cnt = 0;
        int ex_need = 0;
        repeat (3) @(negedge clk);
        // R1 reset state while held in reset
        chk("R1", 32'(phase), 32'd0, "reset phase");
        chk("R1", 32'(tunit), 32'd0, "reset tunit");
        chk("R1", 32'(pc), 32'(BOOT), "reset pc");
        chk("R1", 32'(ie), 32'd0, "reset ie");
        chk("R1", 32'(ir), 32'd0, "reset ir");
        chk("R1", 32'(mem_rd | mem_wr), 32'd0, "reset strobes");
        rst_n = 1'b1;
        for (int cyc = 0; cyc < RUN_CYC; cyc++) begin
            @(negedge clk);
            compare_all();
            if (exec_go) begin
                exec_done = (ex_cnt >= ex_need);
                ex_cnt++;
            end else begin
                if (ex_cnt != 0) ex_need = (ex_need + 1) % 3;
                exec_done = 1'b0;
                ex_cnt = 0;
            end
            irq_pend = (cyc >= 40 && cyc < 250) || (cyc >= 400 && cyc < 700);
            ie_set = (cyc == 20) || (cyc == 300) || (cyc >= 500 && cyc < 560);
        end
        chk("R8", 32'(n_intr >= 2), 32'd1, "interrupts taken");
        chk("R7", 32'(n_ign >= 1), 32'd1, "pending ignored with flag clear");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule